// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel left and right sample words. It watches a bit clock, a word-select clock and one serial data line, all oversampled by the system clock through a short synchronizer. It gathers one word in each half of the word-select period and presents both channels together with a single-cycle strobe once the right-channel word of a frame is complete.

A static two-bit format input picks one of four framings. Two are front-aligned: I2S, where the first bit of a half is a leftover and the MSB follows one bit clock later, and left-justified, where the MSB is on the first bit clock of the half. Two are back-aligned, right-justified with 24 or 16 bits, where the word is located by counting back from the next word-select transition. Every sample leaves MSB-aligned in a 24-bit word. For the back-aligned framings the receiver checks that each half holds enough bit clocks and drops the frame with an error pulse when it does not.

The control path is a three-state machine. HUNT waits for the first bit-clock rising edge after reset and records word-select (transition HUNT to ALIGN, taken on that edge). ALIGN discards bits until word-select changes (transition ALIGN to COLLECT, the alignment edge). COLLECT gathers bits and, on every word-select change (the half-close transition, COLLECT to COLLECT), hands the finished word to the output stage and starts the next half. Only reset leaves COLLECT.

Top module: `sar_rx`

## Requirements
- R1: Serial data and word-select are taken only at rising edges of the bit clock; changes of the data line while the bit clock is high have no effect on the received words.
- R2: fmt_i selects the framing: 0 = I2S (word-select low carries left), 1 = left-justified, 2 = right-justified 24-bit, 3 = right-justified 16-bit (for 1, 2 and 3 word-select high carries left).
- R3: In I2S the bit taken at the first bit-clock edge of a half is discarded and the next bit is the MSB.
- R4: In left-justified framing the bit taken at the first bit-clock edge of a half is the MSB.
- R5: In the front-aligned framings at most 24 bits are kept per half; later bits are ignored, and a half with fewer usable bits leaves the low-order bits zero.
- R6: In right-justified 24-bit framing the word is the last 24 bits before the word-select transition, the last one being the LSB; a half of exactly 24 bit clocks is accepted.
- R7: In right-justified 16-bit framing the word is the last 16 bits before the transition, presented in bits 23:8 with bits 7:0 zero; a half of exactly 16 bit clocks is accepted and earlier bits are ignored.
- R8: A right-justified half shorter than the word (24 or 16 bit clocks) raises short_o for one cycle, and no valid_o is given for that frame.
- R9: valid_o is a one-cycle pulse after a right-channel half closes, presenting it with the left word of the same frame; left_o and right_o change only together with valid_o.
- R10: After reset nothing is emitted until a word-select transition has been seen; a right word without a complete left word before it in the same frame gives no valid_o.
- R11: During and after reset left_o and right_o are zero and valid_o and short_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word-select (frame) clock |
| sd_i | input | 1 | Serial data |
| fmt_i | input | 2 | Framing select, static while running |
| left_o | output | 24 | Left sample, MSB-aligned |
| right_o | output | 24 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe, both samples new |
| short_o | output | 1 | One-cycle pulse for a too-short right-justified half |

## Verification
The hardest case to reach from the ports is a right word that arrives with no accepted left word in front of it, either because the stream started in the middle of a frame or because the left half was too short. The stimulus reaches it by releasing reset in the middle of a left half, so that the partial half is swallowed by alignment and the first collected half is a right one. A separate run sends a right-justified left half with too few bit clocks in front of a full right half. In both cases the bench checks that valid_o stays low and that the outputs keep their old values.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        FMT_I2S  = 2'd0,
        FMT_LJ   = 2'd1,
        FMT_RJ24 = 2'd2,
        FMT_RJ16 = 2'd3
    } sar_fmt_e;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_ALIGN   = 2'd1,
        ST_COLLECT = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_rx_sync.sv
module sar_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic bit_evt,
    output logic ws_s,
    output logic sd_s
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] chain [STAGES];
    logic            bclk_prev;

    assign raw = {sd_i, ws_i, bclk_i};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= '0;
                else        chain[0] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_prev <= 1'b0;
        else        bclk_prev <= chain[STAGES-1][0];
    end

    assign bit_evt = chain[STAGES-1][0] & ~bclk_prev;
    assign ws_s    = chain[STAGES-1][1];
    assign sd_s    = chain[STAGES-1][2];

    AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_evt |=> !bit_evt); // R1
endmodule

// File: rtl/sar_rx_framer.sv
module sar_rx_framer
    import sar_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int SHORT_W = 16,
    parameter int CNT_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_i,
    input  logic              bit_evt,
    input  logic              ws_s,
    input  logic              sd_s,
    output logic              fin_evt,
    output logic              fin_left,
    output logic              fin_short,
    output logic [DATA_W-1:0] fin_word
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam int               PAD_W   = DATA_W - SHORT_W;

    sar_fmt_e          fmt;
    sar_state_e        state_q, state_d;
    logic              ws_prev_q, ws_prev_d;
    logic [DATA_W-1:0] acc_q, acc_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DATA_W-1:0] first_acc, next_acc;
    logic              is_rj, is_i2s, ws_edge;
    int                need, pos;

    assign fmt     = sar_fmt_e'(fmt_i);
    assign is_rj   = (fmt == FMT_RJ24) || (fmt == FMT_RJ16);
    assign is_i2s  = (fmt == FMT_I2S);
    assign ws_edge = (ws_s != ws_prev_q);
    assign need    = (fmt == FMT_RJ16) ? SHORT_W : DATA_W;
    assign pos     = int'(cnt_q) - (is_i2s ? 1 : 0);

    // word register contents at the first bit of a half
    always_comb begin
        unique case (fmt)
            FMT_I2S: first_acc = '0;
            FMT_LJ:  first_acc = {sd_s, {(DATA_W-1){1'b0}}};
            default: first_acc = {{(DATA_W-1){1'b0}}, sd_s};
        endcase
    end

    // word register contents for a later bit of a half
    always_comb begin
        next_acc = acc_q;
        if (is_rj) begin
            next_acc = {acc_q[DATA_W-2:0], sd_s};
        end else begin
            for (int b = 0; b < DATA_W; b++) begin
                if (pos >= 0 && pos < DATA_W && b == DATA_W - 1 - pos)
                    next_acc[b] = sd_s;
            end
        end
    end

    // next-state and datapath
    always_comb begin
        state_d   = state_q;
        ws_prev_d = ws_prev_q;
        acc_d     = acc_q;
        cnt_d     = cnt_q;
        fin_evt   = 1'b0;
        if (bit_evt) begin
            ws_prev_d = ws_s;
            unique case (state_q)
                ST_HUNT: begin
                    state_d = ST_ALIGN;
                end
                ST_ALIGN: begin
                    if (ws_edge) begin
                        state_d = ST_COLLECT;
                        acc_d   = first_acc;
                        cnt_d   = CNT_W'(1);
                    end
                end
                ST_COLLECT: begin
                    if (ws_edge) begin
                        fin_evt = 1'b1;
                        acc_d   = first_acc;
                        cnt_d   = CNT_W'(1);
                    end else begin
                        acc_d = next_acc;
                        if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_HUNT;
            ws_prev_q <= 1'b0;
            acc_q     <= '0;
            cnt_q     <= '0;
        end else begin
            state_q   <= state_d;
            ws_prev_q <= ws_prev_d;
            acc_q     <= acc_d;
            cnt_q     <= cnt_d;
        end
    end

    // half-close outputs
    always_comb begin
        fin_left  = is_i2s ? ~ws_prev_q : ws_prev_q;
        fin_short = is_rj && (int'(cnt_q) < need);
        if (fmt == FMT_RJ16) fin_word = {acc_q[SHORT_W-1:0], {PAD_W{1'b0}}};
        else                 fin_word = acc_q;
    end

    AST_COLLECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_COLLECT |=> state_q == ST_COLLECT); // R10
    AST_ALIGN_FROM_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_ALIGN) |-> $past(state_q) == ST_HUNT); // R10
endmodule

// File: rtl/sar_rx_outreg.sv
module sar_rx_outreg #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin_evt,
    input  logic              fin_left,
    input  logic              fin_short,
    input  logic [DATA_W-1:0] fin_word,
    output logic [DATA_W-1:0] left_o,
    output logic [DATA_W-1:0] right_o,
    output logic              valid_o,
    output logic              short_o
);
    logic [DATA_W-1:0] hold_q;
    logic              left_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            left_ok_q <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
            short_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            short_o <= 1'b0;
            if (fin_evt) begin
                if (fin_short) begin
                    short_o   <= 1'b1;
                    left_ok_q <= 1'b0;
                end else if (fin_left) begin
                    hold_q    <= fin_word;
                    left_ok_q <= 1'b1;
                end else begin
                    left_ok_q <= 1'b0;
                    if (left_ok_q) begin
                        left_o  <= hold_q;
                        right_o <= fin_word;
                        valid_o <= 1'b1;
                    end
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R9
    AST_SHORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        short_o |=> !short_o); // R8
    AST_SHORT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(short_o && valid_o)); // R8
    AST_VALID_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(fin_evt) && !$past(fin_left)); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(left_o) && $stable(right_o)); // R9
endmodule

// File: rtl/sar_rx.sv
module sar_rx #(
    parameter int DATA_W  = 24,
    parameter int SHORT_W = 16,
    parameter int CNT_W   = 7,
    parameter int STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              ws_i,
    input  logic              sd_i,
    input  logic [1:0]        fmt_i,
    output logic [DATA_W-1:0] left_o,
    output logic [DATA_W-1:0] right_o,
    output logic              valid_o,
    output logic              short_o
);
    logic              bit_evt, ws_s, sd_s;
    logic              fin_evt, fin_left, fin_short;
    logic [DATA_W-1:0] fin_word;

    sar_rx_sync #(.STAGES(STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_i  (bclk_i),
        .ws_i    (ws_i),
        .sd_i    (sd_i),
        .bit_evt (bit_evt),
        .ws_s    (ws_s),
        .sd_s    (sd_s)
    );

    sar_rx_framer #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .CNT_W(CNT_W)) framer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_i     (fmt_i),
        .bit_evt   (bit_evt),
        .ws_s      (ws_s),
        .sd_s      (sd_s),
        .fin_evt   (fin_evt),
        .fin_left  (fin_left),
        .fin_short (fin_short),
        .fin_word  (fin_word)
    );

    sar_rx_outreg #(.DATA_W(DATA_W)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fin_evt   (fin_evt),
        .fin_left  (fin_left),
        .fin_short (fin_short),
        .fin_word  (fin_word),
        .left_o    (left_o),
        .right_o   (right_o),
        .valid_o   (valid_o),
        .short_o   (short_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !short_o) || !rst_n); // R11
endmodule

// File: tb/sar_rx_tb.sv
`timescale 1ns/1ps
module sar_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [23:0] left_o, right_o;
    logic        valid_o, short_o;
    int          total = 0, bad = 0, vcnt = 0, scnt = 0;

    always #10 clk = ~clk;

    sar_rx dut_i (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .ws_i(ws), .sd_i(sd),
        .fmt_i(fmt), .left_o(left_o), .right_o(right_o),
        .valid_o(valid_o), .short_o(short_o)
    );

    always @(negedge clk) begin
        if (rst_n && valid_o) vcnt++;
        if (rst_n && short_o) scnt++;
    end

    // fmt, half length, bits sent, left word, right word
    localparam logic [65:0] VEC [10] = '{
        {2'd0, 8'd32, 8'd24, 24'hA5C3F1, 24'h5A3C0E},
        {2'd0, 8'd32, 8'd16, 24'h123456, 24'hFEDCBA},
        {2'd1, 8'd32, 8'd24, 24'h800001, 24'h7FFFFE},
        {2'd1, 8'd32, 8'd32, 24'hC0FFEE, 24'h0BEEF1},
        {2'd1, 8'd20, 8'd24, 24'h9ABCDE, 24'h13579B},
        {2'd2, 8'd32, 8'd24, 24'h876543, 24'h0F1E2D},
        {2'd2, 8'd24, 8'd24, 24'hFFFFFF, 24'h000001},
        {2'd3, 8'd32, 8'd16, 24'h00BEEF, 24'h001234},
        {2'd3, 8'd16, 8'd16, 24'h00F00F, 24'h008001},
        {2'd0, 8'd25, 8'd24, 24'h3C3C3C, 24'hC3C3C3}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    // one bit clock; data flips while high to prove it is not sampled there
    task automatic bit_out(input logic wsv, input logic b);
        @(negedge clk);
        bclk = 1'b0; ws = wsv; sd = b;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
        sd = ~b;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic left_ws(input logic [1:0] f);
        return (f == 2'd0) ? 1'b0 : 1'b1;
    endfunction

    task automatic send_half(input logic wsv, input logic [23:0] w, input int nb, input int hl);
        for (int i = 0; i < hl; i++) begin
            logic b;
            if (fmt == 2'd0 || fmt == 2'd1) begin
                int j = (fmt == 2'd0) ? i - 1 : i;
                if (j < 0)                   b = 1'b1;
                else if (j < nb && j < 24)   b = w[23-j];
                else                         b = (j >= 24);
            end else begin
                int k = hl - 1 - i;
                int need = (fmt == 2'd3) ? 16 : 24;
                b = (k < need) ? w[k] : 1'b1;
            end
            bit_out(wsv, b);
        end
    endtask

    function automatic logic [23:0] exp_word(input logic [1:0] f, input logic [23:0] w,
                                             input int nb, input int hl);
        int keep;
        if (f == 2'd2) return w;
        if (f == 2'd3) return {w[15:0], 8'h00};
        keep = (f == 2'd0) ? hl - 1 : hl;
        if (nb < keep) keep = nb;
        if (keep > 24) keep = 24;
        return w & ~(24'hFFFFFF >> keep);
    endfunction

    task automatic do_reset(input logic [1:0] f);
        @(negedge clk);
        rst_n = 1'b0; bclk = 1'b0; fmt = f;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int vb, sb;
        logic lw;
        // R11: reset state
        do_reset(2'd1);
        repeat (3) @(negedge clk);
        chk("R11 reset left", 32'(left_o), 32'h0);
        chk("R11 reset right", 32'(right_o), 32'h0);
        chk("R11 reset strobes", {30'h0, valid_o, short_o}, 32'h0);

        // table walk: R1 R2 R9 plus per-format R3 R4 R5 R6 R7
        for (int v = 0; v < 10; v++) begin
            logic [1:0] f = VEC[v][65:64];
            int hl = int'(VEC[v][63:56]);
            int nb = int'(VEC[v][55:48]);
            string tg = (f == 2'd0) ? "R3 R5" : (f == 2'd1) ? "R4 R5" : (f == 2'd2) ? "R6" : "R7";
            do_reset(f);
            lw = left_ws(f);
            vb = vcnt; sb = scnt;
            send_half(~lw, 24'h0, 0, 3);
            send_half(lw, VEC[v][47:24], nb, hl);
            send_half(~lw, VEC[v][23:0], nb, hl);
            send_half(lw, 24'h0, 0, 2);
            repeat (10) @(negedge clk);
            chk($sformatf("R1 R2 %s vec%0d left", tg, v), 32'(left_o),
                32'(exp_word(f, VEC[v][47:24], nb, hl)));
            chk($sformatf("R1 R2 %s vec%0d right", tg, v), 32'(right_o),
                32'(exp_word(f, VEC[v][23:0], nb, hl)));
            chk($sformatf("R9 vec%0d valid count", v), 32'(vcnt - vb), 32'd1);
            chk($sformatf("R8 vec%0d no short", v), 32'(scnt - sb), 32'd0);
        end

        // R8: short left half in RJ24
        do_reset(2'd2);
        vb = vcnt; sb = scnt;
        send_half(1'b0, 24'h0, 0, 3);
        send_half(1'b1, 24'hABCDEF, 24, 20);
        send_half(1'b0, 24'h123456, 24, 32);
        send_half(1'b1, 24'h0, 0, 2);
        repeat (10) @(negedge clk);
        chk("R8 short left pulse", 32'(scnt - sb), 32'd1);
        chk("R8 short left no valid", 32'(vcnt - vb), 32'd0);
        chk("R8 short left output kept", 32'(right_o), 32'h0);

        // R8 R7: short right half in RJ16 (15 clocks), 16 accepted above
        do_reset(2'd3);
        vb = vcnt; sb = scnt;
        send_half(1'b0, 24'h0, 0, 3);
        send_half(1'b1, 24'h001111, 16, 16);
        send_half(1'b0, 24'h002222, 16, 15);
        send_half(1'b1, 24'h0, 0, 2);
        repeat (10) @(negedge clk);
        chk("R8 R7 short right pulse", 32'(scnt - sb), 32'd1);
        chk("R8 R7 short right no valid", 32'(vcnt - vb), 32'd0);

        // R10: start inside a left half, first collected half is a right one
        do_reset(2'd1);
        vb = vcnt;
        send_half(1'b1, 24'hFFFFFF, 24, 10);
        send_half(1'b0, 24'hEEEEEE, 24, 32);
        repeat (10) @(negedge clk);
        chk("R10 partial half gives nothing", 32'(vcnt - vb), 32'd0);
        send_half(1'b1, 24'h246801, 24, 32);
        repeat (10) @(negedge clk);
        chk("R10 lone right word gives no valid", 32'(vcnt - vb), 32'd0);
        send_half(1'b0, 24'h135702, 24, 32);
        send_half(1'b1, 24'h0, 0, 2);
        repeat (10) @(negedge clk);
        chk("R10 first full frame valid", 32'(vcnt - vb), 32'd1);
        chk("R10 first full frame left", 32'(left_o), 32'h246801);
        chk("R10 first full frame right", 32'(right_o), 32'h135702);

        // R9: a closed left half alone does not move the outputs
        vb = vcnt;
        send_half(1'b0, 24'h999999, 24, 32);
        repeat (10) @(negedge clk);
        chk("R9 left close keeps left_o", 32'(left_o), 32'h246801);
        chk("R9 left close keeps right_o", 32'(right_o), 32'h135702);
        chk("R9 left close no valid", 32'(vcnt - vb), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule